// File: doc/BRIEF.md
# Synthesizer Configuration Word Interface

This block holds the configuration word that programs a PLL clock synthesizer. The word has three fields: a 7-bit feedback count, a 2-bit output-divider code and a 3-bit test field. The active word feeds the synthesizer's dividers straight from registered outputs.

The word can be loaded in two ways. At power-up, a parallel-load control held low makes the active word follow the feedback-count and divider-code pins. Its rising edge freezes the word. Later, a three-wire serial port can reprogram the word. The port has a shift clock, a data line and a load strobe. Bits enter a 12-bit staging chain. The staged bits only reach the active word while the load strobe is high.

All serial and parallel-load controls are asynchronous to the system clock. They pass through a synchronizer of `SYNC_STAGES` flops, and all logic runs on the single system clock. The divider and count pins are expected to be stable while the parallel-load control is low.

Top module: `synth_cfg_if`

## Requirements
- R1: While synchronous reset is high, and on the first sampled cycle after it, the feedback count, divider code and test outputs are all zero.
- R2: While the parallel-load control is low, the feedback-count and divider-code outputs follow their pins, and the test output is held at zero.
- R3: After the parallel-load control rises, the outputs keep the last pin values, and later pin changes have no effect.
- R4: One serial bit is sampled on each rising edge of the shift clock. A 12-bit word is sent as test bit 2 first, then test bits 1 and 0, then divider code bits 1 and 0, then feedback count bits 6 down to 0, so count bit 0 is sent last.
- R5: Shifting bits while the load strobe is low never changes any output.
- R6: The load strobe is level-sensitive. While it is high (and the parallel-load control is high), the outputs track the staging chain, including bits shifted in during the strobe. When it returns low, the outputs hold.
- R7: While the parallel-load control is low, a high load strobe is ignored and the outputs show the pin values with a zero test field.
- R8: The staging chain keeps only the most recent 12 bits. When more than 12 bits are shifted, the earliest ones are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_load_n | input | 1 | Parallel-load control, active low (asynchronous) |
| m_pin | input | 7 | Parallel feedback-count pins |
| n_pin | input | 2 | Parallel divider-code pins |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data line (asynchronous) |
| ser_load | input | 1 | Serial load strobe, level-sensitive (asynchronous) |
| m_out | output | 7 | Active feedback count |
| n_out | output | 2 | Active divider code |
| test_out | output | 3 | Active test field |

## Verification
The hardest case to reach is a strobe that is held high while further shift-clock edges arrive. There, the outputs must move one bit at a time with the chain and then freeze when the strobe drops.

The bench raises the strobe and streams a complete second word through the port without lowering it. It then checks that the outputs equal that second word. Next, it shifts a third word with the strobe low and checks that nothing moved.

The conflict between the parallel path and the serial path is reached by holding the parallel control low and raising the strobe over a staged word. In that state the pin values must win.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int M_W     = 7;
  localparam int N_W     = 2;
  localparam int T_W     = 3;
  localparam int CHAIN_W = T_W + N_W + M_W;

  // Field order matches the serial order: test first, count last.
  typedef struct packed {
    logic [T_W-1:0] test;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_word_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_s,
  input  logic         sdata_s,
  output logic [W-1:0] chain
);
  logic sclk_prev;
  logic shift_en;

  assign shift_en = sclk_s & ~sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      chain     <= '0;
    end else begin
      sclk_prev <= sclk_s;
      if (shift_en) chain <= {chain[W-2:0], sdata_s};
    end
  end

  // R4: one new bit enters at the low end on each detected edge.
  p_shift_order_r4: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (chain == {$past(chain[W-2:0]), $past(sdata_s)}));

  // R8: the chain moves only on an edge, so older bits fall off the top.
  p_chain_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(chain));

  // R4: a level-high shift clock gives a single sample.
  p_single_edge_r4: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> !shift_en);
endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
  import cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      par_sel,
  input  logic      ser_sel,
  input  cfg_word_t par_word,
  input  cfg_word_t ser_word,
  output cfg_word_t active
);
  always_ff @(posedge clk) begin
    if (rst)          active <= '0;
    else if (par_sel) active <= par_word;
    else if (ser_sel) active <= ser_word;
  end

  // R7: parallel control overrides a concurrent strobe.
  p_par_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (par_sel && ser_sel) |=> (active == $past(par_word)));

  // R6: strobe high tracks the chain.
  p_ser_track_r6: assert property (@(posedge clk) disable iff (rst)
    (!par_sel && ser_sel) |=> (active == $past(ser_word)));

  // R5: no select means no change.
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!par_sel && !ser_sel) |=> $stable(active));
endmodule

// File: rtl/synth_cfg_if.sv
module synth_cfg_if
  import cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           par_load_n,
  input  logic [M_W-1:0] m_pin,
  input  logic [N_W-1:0] n_pin,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  output logic [M_W-1:0] m_out,
  output logic [N_W-1:0] n_out,
  output logic [T_W-1:0] test_out
);
  localparam int CTRL_W = 4;
  localparam logic [CTRL_W-1:0] CTRL_RST = 4'b1000;

  logic [CTRL_W-1:0] ctrl_s;
  logic [CHAIN_W-1:0] chain;
  cfg_word_t par_word;
  cfg_word_t ser_word;
  cfg_word_t active;

  cfg_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (CTRL_W),
    .RST_VAL(CTRL_RST)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({par_load_n, ser_load, ser_data, ser_clk}),
    .q  (ctrl_s)
  );

  cfg_shift_chain #(.W(CHAIN_W)) u_chain (
    .clk    (clk),
    .rst    (rst),
    .sclk_s (ctrl_s[0]),
    .sdata_s(ctrl_s[1]),
    .chain  (chain)
  );

  always_comb begin
    par_word      = '0;
    par_word.m    = m_pin;
    par_word.n    = n_pin;
    ser_word      = cfg_word_t'(chain);
  end

  cfg_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .par_sel (~ctrl_s[3]),
    .ser_sel (ctrl_s[2]),
    .par_word(par_word),
    .ser_word(ser_word),
    .active  (active)
  );

  assign m_out    = active.m;
  assign n_out    = active.n;
  assign test_out = active.test;

  // R2: parallel path clears the test field.
  p_par_test_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !ctrl_s[3] |=> (test_out == '0));

  // R1: first cycle after reset shows zeros.
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (m_out == '0 && n_out == '0 && test_out == '0));
endmodule

// File: tb/synth_cfg_if_test.sv
module synth_cfg_if_test;
  logic clk = 0;
  logic rst = 1;
  logic par_load_n = 1;
  logic [6:0] m_pin = 0;
  logic [1:0] n_pin = 0;
  logic ser_clk = 0, ser_data = 0, ser_load = 0;
  logic [6:0] m_out;
  logic [1:0] n_out;
  logic [2:0] test_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  synth_cfg_if uut (
    .clk(clk), .rst(rst), .par_load_n(par_load_n),
    .m_pin(m_pin), .n_pin(n_pin),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .m_out(m_out), .n_out(n_out), .test_out(test_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] t,
                       input logic [1:0] n, input logic [6:0] m);
    total = total + 1;
    if (test_out !== t || n_out !== n || m_out !== m) begin
      bad = bad + 1;
      $display("FAIL %s: actual t=%0d n=%0d m=%0d expected t=%0d n=%0d m=%0d",
               req, test_out, n_out, m_out, t, n, m);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_data = b; tick(3);
    ser_clk = 1;  tick(3);
    ser_clk = 0;  tick(3);
  endtask

  task automatic send_word(input logic [2:0] t, input logic [1:0] n,
                           input logic [6:0] m);
    logic [11:0] w;
    w = {t, n, m};
    for (int i = 11; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic strobe();
    ser_load = 1; tick(5);
    ser_load = 0; tick(5);
  endtask

  initial begin
    logic [6:0] m_e;
    logic [1:0] n_e;
    logic [2:0] t_e;
    tick(4);
    check("R1", 3'd0, 2'd0, 7'd0);
    rst = 0;
    tick(1);
    check("R1", 3'd0, 2'd0, 7'd0);

    // R2: exhaustive parallel sweep
    par_load_n = 0;
    for (int m = 0; m < 128; m++) begin
      for (int n = 0; n < 4; n++) begin
        m_pin = 7'(m); n_pin = 2'(n);
        tick(4);
        check("R2", 3'd0, 2'(n), 7'(m));
      end
    end

    // R3: freeze on rising edge of control
    m_pin = 7'd93; n_pin = 2'd2; tick(4);
    par_load_n = 1; tick(5);
    m_pin = 7'd14; n_pin = 2'd1; tick(6);
    check("R3", 3'd0, 2'd2, 7'd93);

    // R4: serial words covering every test value and walking count bits
    for (int t = 0; t < 8; t++) begin
      t_e = 3'(t); n_e = 2'(t); m_e = 7'((t * 37 + 5) % 128);
      send_word(t_e, n_e, m_e);
      strobe();
      check("R4", t_e, n_e, m_e);
    end
    for (int b = 0; b < 7; b++) begin
      m_e = 7'(1 << b); n_e = 2'(b % 4); t_e = 3'(7 - b);
      send_word(t_e, n_e, m_e);
      strobe();
      check("R4", t_e, n_e, m_e);
    end

    // R5: shifting without strobe changes nothing
    send_word(3'd5, 2'd3, 7'd100);
    strobe();
    send_word(3'd2, 2'd1, 7'd27);
    check("R5", 3'd5, 2'd3, 7'd100);
    strobe();
    check("R5", 3'd2, 2'd1, 7'd27);

    // R6: strobe held high while a new word arrives
    ser_load = 1; tick(5);
    send_word(3'd6, 2'd0, 7'd81);
    check("R6", 3'd6, 2'd0, 7'd81);
    ser_load = 0; tick(5);
    send_word(3'd1, 2'd2, 7'd3);
    check("R6", 3'd6, 2'd0, 7'd81);

    // R8: 15 bits shifted, first three dropped
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_word(3'd3, 2'd1, 7'd66);
    strobe();
    check("R8", 3'd3, 2'd1, 7'd66);

    // R7: parallel control low overrides a high strobe
    send_word(3'd7, 2'd3, 7'd127);
    m_pin = 7'd42; n_pin = 2'd2;
    par_load_n = 0; ser_load = 1; tick(6);
    check("R7", 3'd0, 2'd2, 7'd42);
    ser_load = 0; tick(3);
    par_load_n = 1; tick(6);
    check("R7", 3'd0, 2'd2, 7'd42);

    // R1: reset again clears active word
    rst = 1; tick(2);
    check("R1", 3'd0, 2'd0, 7'd0);
    rst = 0; tick(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule